// File: doc/BRIEF.md
# Sixteen-bit I/O expander core

The core holds the registers and pin control for a 16-bit general purpose I/O expander arranged as two 8-bit ports. For each port it keeps a direction register, an output value register, a polarity inversion register, an input latch enable register, a pull enable register, a pull direction register and an interrupt mask register. A status register for each port is read-only, and one output-mode register chooses open-drain or push-pull drive per port. It drives the pin output enables and output levels. It passes the pin inputs through a two-flop synchroniser. It exports the pull control bits so the surrounding pad logic can act on them.

A host reaches the registers through a flat parallel port with an address, write data, a write strobe, a read strobe and registered read data. Every bit has a compare reference, which holds the raw pin level captured when the port's input register was last read. A pin that is configured as an input, is unmasked and differs from its reference pulls the active-low interrupt line down. A pin with its latch bit set also holds any change it sees until the next read of its input register, even if the pin goes back to its old level. The interrupt masks come out of reset all set, so nothing fires until software clears them.

Top module: `gpx_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, the registers read their defaults. Direction is 0xFF (all inputs), output is 0xFF, pull direction is 0xFF, and polarity, latch and pull enable are 0x00. The output-mode register is 0. `int_n` is 1, `pin_oe` is 0 and `pin_out` is all ones.
- R2: The register map is as follows, with the low address bit selecting the port: input 0x00/0x01, output 0x02/0x03, polarity 0x04/0x05, direction 0x06/0x07, latch 0x44/0x45, pull enable 0x46/0x47, pull direction 0x48/0x49, mask 0x4A/0x4B, status 0x4C/0x4D, output mode 0x4F. `rdata` holds the value at the clock edge after `rd_en`. Unmapped addresses read 0 and ignore writes.
- R3: An input register reads the synchronised pin level XOR its polarity bit. Writes to the input and status addresses have no effect.
- R4: A direction bit of 0 makes the pin an output. `pin_oe` is then 1 and `pin_out` follows the output register bit. A direction bit of 1 keeps `pin_oe` at 0.
- R5: Output-mode bit 0 selects port 0 and bit 1 selects port 1. A value of 1 means open-drain, and in that mode an output pin whose output bit is 1 has `pin_oe` at 0.
- R6: `int_n` goes low when an input pin is unmasked and differs from its compare reference. It is high otherwise.
- R7: Every mask bit resets to 1 (masked). A masked pin never drives `int_n` low.
- R8: Reading a port's input register loads that port's references from the current pins. This clears its status bits and the held latch state.
- R9: When a pin has its latch bit set, a change is held until its input register is read. The input register returns the held level (XOR polarity), and the interrupt stays set even after the pin returns. A pin without a latch bit stops interrupting once it returns to its reference.
- R10: A status register bit is 1 exactly when that pin is an input, is unmasked, and is either pending a latched change or differs from its reference.
- R11: `pull_en` and `pull_up` give the pull enable and pull direction registers of both ports. Port 1 drives bits 15:8.
- R12: Pins configured as outputs never set status or interrupt, whatever their pin level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, holds defaults while high |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| pin_in | input | 16 | Raw pin levels, port 1 on bits 15:8 |
| pin_oe | output | 16 | Pin output enables |
| pin_out | output | 16 | Pin output levels |
| pull_en | output | 16 | Pull resistor enables |
| pull_up | output | 16 | Pull direction, 1 selects pull-up |
| int_n | output | 1 | Active-low interrupt |

## Verification
The bench goes after four cases:
- A latched pin that toggles and returns before a read. A design that compared live pins only would drop the interrupt and report the current level instead of the held one.
- A read that races the reference update. If the design cleared the wrong port, or kept held state after the read, `int_n` would stay low.
- Open-drain ports with output bits at 1. A wrong design would actively drive high.
- Output-configured pins whose level changes, which must stay silent.

Random register traffic, random pin patterns and reads of unmapped addresses run against a bench model. They expose decode slips and polarity applied to the reference instead of the reported value.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int NPORTS = 2;
  localparam int ADDR_W = 8;

  typedef enum logic [3:0] {
    RK_NONE, RK_IN, RK_OUT, RK_POL, RK_CFG, RK_LAT,
    RK_PEN, RK_PSEL, RK_MSK, RK_STS, RK_OMODE
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e kind;
    logic      port;
  } reg_sel_t;

  // Map an address onto a register kind and port index.
  function automatic reg_sel_t decode(input logic [ADDR_W-1:0] a);
    reg_sel_t r;
    r.kind = RK_NONE;
    r.port = a[0];
    case (a[ADDR_W-1:1])
      7'h00: r.kind = RK_IN;
      7'h01: r.kind = RK_OUT;
      7'h02: r.kind = RK_POL;
      7'h03: r.kind = RK_CFG;
      7'h22: r.kind = RK_LAT;
      7'h23: r.kind = RK_PEN;
      7'h24: r.kind = RK_PSEL;
      7'h25: r.kind = RK_MSK;
      7'h26: r.kind = RK_STS;
      7'h27: r.kind = a[0] ? RK_OMODE : RK_NONE;
      default: r.kind = RK_NONE;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] st [STAGES];

  always_ff @(posedge clk) st[0] <= d;

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) st[g] <= st[g-1];
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/gpx_port.sv
module gpx_port
  import gpx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_stb,
  input  reg_kind_e wr_kind,
  input  logic [W-1:0] wdata,
  input  logic      rd_in_stb,
  input  logic      od,
  input  logic [W-1:0] pin_s,
  output logic [W-1:0] cfg_q,
  output logic [W-1:0] out_q,
  output logic [W-1:0] pol_q,
  output logic [W-1:0] lat_q,
  output logic [W-1:0] pen_q,
  output logic [W-1:0] psel_q,
  output logic [W-1:0] msk_q,
  output logic [W-1:0] in_val,
  output logic [W-1:0] status,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] pin_out
);
  logic [W-1:0] ref_q, hit_q, hv_q;
  logic [W-1:0] diff, set_v, pend;

  // Host-writable registers
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '1;
      out_q  <= '1;
      pol_q  <= '0;
      lat_q  <= '0;
      pen_q  <= '0;
      psel_q <= '1;
      msk_q  <= '1;
    end else if (wr_stb) begin
      case (wr_kind)
        RK_OUT:  out_q  <= wdata;
        RK_POL:  pol_q  <= wdata;
        RK_CFG:  cfg_q  <= wdata;
        RK_LAT:  lat_q  <= wdata;
        RK_PEN:  pen_q  <= wdata;
        RK_PSEL: psel_q <= wdata;
        RK_MSK:  msk_q  <= wdata;
        default: ;
      endcase
    end
  end

  // Change detection against the reference captured at the last read
  assign diff   = pin_s ^ ref_q;
  assign set_v  = cfg_q & lat_q & diff & ~hit_q;
  assign pend   = cfg_q & (hit_q | diff);
  assign status = pend & ~msk_q;
  assign in_val = ((hv_q & hit_q) | (pin_s & ~hit_q)) ^ pol_q;

  always_ff @(posedge clk) begin
    if (rst || rd_in_stb) begin
      ref_q <= pin_s;
      hit_q <= '0;
      hv_q  <= '0;
    end else begin
      hit_q <= hit_q | set_v;
      hv_q  <= (hv_q & ~set_v) | (pin_s & set_v);
    end
  end

  // Registered pin drive
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_oe  <= '0;
      pin_out <= '1;
    end else begin
      pin_out <= out_q;
      pin_oe  <= ~cfg_q & ~({W{od}} & out_q);
    end
  end

  assert_mask_reset_R7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (msk_q == '1));

  assert_read_clears_hold_R9: assert property (@(posedge clk) disable iff (rst)
    rd_in_stb |=> (hit_q == '0));

  assert_input_no_drive_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((pin_oe & $past(cfg_q)) == '0));

  assert_open_drain_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(od)) |-> ((pin_oe & pin_out) == '0));

  assert_out_pin_silent_R12: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (($past(status) & ~$past(cfg_q)) == '0));
endmodule

// File: rtl/gpx_top.sv
module gpx_top
  import gpx_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [PORT_W-1:0]        wdata,
  input  logic                     wr_en,
  input  logic                     rd_en,
  output logic [PORT_W-1:0]        rdata,
  input  logic [NPORTS*PORT_W-1:0] pin_in,
  output logic [NPORTS*PORT_W-1:0] pin_oe,
  output logic [NPORTS*PORT_W-1:0] pin_out,
  output logic [NPORTS*PORT_W-1:0] pull_en,
  output logic [NPORTS*PORT_W-1:0] pull_up,
  output logic                     int_n
);
  localparam int TOT_W = NPORTS * PORT_W;

  reg_sel_t          sel;
  logic [TOT_W-1:0]  pin_s;
  logic [NPORTS-1:0] od_q;
  logic [PORT_W-1:0] rd_val;
  logic              sts_any;

  logic [PORT_W-1:0] cfg_a [NPORTS];
  logic [PORT_W-1:0] out_a [NPORTS];
  logic [PORT_W-1:0] pol_a [NPORTS];
  logic [PORT_W-1:0] lat_a [NPORTS];
  logic [PORT_W-1:0] pen_a [NPORTS];
  logic [PORT_W-1:0] psel_a[NPORTS];
  logic [PORT_W-1:0] msk_a [NPORTS];
  logic [PORT_W-1:0] in_a  [NPORTS];
  logic [PORT_W-1:0] sts_a [NPORTS];

  assign sel = decode(addr);

  gpx_sync #(.WIDTH(TOT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   (pin_in),
    .q   (pin_s)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    gpx_port #(.W(PORT_W)) u_port (
      .clk       (clk),
      .rst       (rst),
      .wr_stb    (wr_en && (int'(sel.port) == p)),
      .wr_kind   (sel.kind),
      .wdata     (wdata),
      .rd_in_stb (rd_en && (sel.kind == RK_IN) && (int'(sel.port) == p)),
      .od        (od_q[p]),
      .pin_s     (pin_s[p*PORT_W +: PORT_W]),
      .cfg_q     (cfg_a[p]),
      .out_q     (out_a[p]),
      .pol_q     (pol_a[p]),
      .lat_q     (lat_a[p]),
      .pen_q     (pen_a[p]),
      .psel_q    (psel_a[p]),
      .msk_q     (msk_a[p]),
      .in_val    (in_a[p]),
      .status    (sts_a[p]),
      .pin_oe    (pin_oe[p*PORT_W +: PORT_W]),
      .pin_out   (pin_out[p*PORT_W +: PORT_W])
    );
    assign pull_en[p*PORT_W +: PORT_W] = pen_a[p];
    assign pull_up[p*PORT_W +: PORT_W] = psel_a[p];
  end

  // Output-mode register, one open-drain bit per port
  always_ff @(posedge clk) begin
    if (rst)                              od_q <= '0;
    else if (wr_en && sel.kind == RK_OMODE) od_q <= wdata[NPORTS-1:0];
  end

  always_comb begin
    rd_val = '0;
    case (sel.kind)
      RK_IN:    rd_val = in_a[sel.port];
      RK_OUT:   rd_val = out_a[sel.port];
      RK_POL:   rd_val = pol_a[sel.port];
      RK_CFG:   rd_val = cfg_a[sel.port];
      RK_LAT:   rd_val = lat_a[sel.port];
      RK_PEN:   rd_val = pen_a[sel.port];
      RK_PSEL:  rd_val = psel_a[sel.port];
      RK_MSK:   rd_val = msk_a[sel.port];
      RK_STS:   rd_val = sts_a[sel.port];
      RK_OMODE: rd_val[NPORTS-1:0] = od_q;
      default:  rd_val = '0;
    endcase
  end

  always_comb begin
    sts_any = 1'b0;
    for (int p = 0; p < NPORTS; p++) sts_any = sts_any | (|sts_a[p]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      int_n <= 1'b1;
    end else begin
      if (rd_en) rdata <= rd_val;
      int_n <= ~sts_any;
    end
  end

  assert_int_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> int_n);

  assert_int_has_cause_R6: assert property (@(posedge clk) disable iff (rst)
    (!int_n && !$past(rst)) |-> $past(sts_any));

  assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_en) && $past(sel.kind == RK_NONE)) |-> (rdata == '0));
endmodule

// File: tb/tb_gpx_top.sv
module tb_gpx_top;
  logic        clk = 0;
  logic        rst = 1;
  logic [7:0]  addr = 0, wdata = 0, rdata;
  logic        wr_en = 0, rd_en = 0, int_n;
  logic [15:0] pin_in = 0, pin_oe, pin_out, pull_en, pull_up;

  int nchk = 0, nerr = 0;

  // Bench model
  logic [15:0] m_cfg, m_out, m_pol, m_lat, m_pen, m_psel, m_msk;
  logic [15:0] m_ref, m_hit, m_hv, pins;
  logic [1:0]  m_od;

  always #5 clk = ~clk;

  gpx_top dut (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en),
    .rdata(rdata), .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out),
    .pull_en(pull_en), .pull_up(pull_up), .int_n(int_n)
  );

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model_reset();
    m_cfg = '1; m_out = '1; m_pol = '0; m_lat = '0; m_pen = '0; m_psel = '1; m_msk = '1;
    m_od = '0; m_ref = pins; m_hit = '0; m_hv = '0;
  endfunction

  function automatic void settle();
    logic [15:0] s;
    s = m_cfg & m_lat & (pins ^ m_ref) & ~m_hit;
    m_hit = m_hit | s;
    m_hv  = (m_hv & ~s) | (pins & s);
  endfunction

  function automatic logic [15:0] exp_sts();
    return m_cfg & (m_hit | (pins ^ m_ref)) & ~m_msk;
  endfunction

  function automatic logic [15:0] exp_in();
    return ((m_hv & m_hit) | (pins & ~m_hit)) ^ m_pol;
  endfunction

  function automatic logic [15:0] exp_oe();
    return ~m_cfg & ~({{8{m_od[1]}}, {8{m_od[0]}}} & m_out);
  endfunction

  function automatic logic [7:0] exp_read(input logic [7:0] a);
    int b;
    logic [15:0] sts, inv;
    b = a[0] ? 8 : 0;
    sts = exp_sts();
    inv = exp_in();
    case (a)
      8'h00, 8'h01: return inv[b +: 8];
      8'h02, 8'h03: return m_out[b +: 8];
      8'h04, 8'h05: return m_pol[b +: 8];
      8'h06, 8'h07: return m_cfg[b +: 8];
      8'h44, 8'h45: return m_lat[b +: 8];
      8'h46, 8'h47: return m_pen[b +: 8];
      8'h48, 8'h49: return m_psel[b +: 8];
      8'h4A, 8'h4B: return m_msk[b +: 8];
      8'h4C, 8'h4D: return sts[b +: 8];
      8'h4F:        return {6'b0, m_od};
      default:      return 8'h00;
    endcase
  endfunction

  function automatic void model_write(input logic [7:0] a, input logic [7:0] d);
    int b;
    b = a[0] ? 8 : 0;
    case (a)
      8'h02, 8'h03: m_out[b +: 8]  = d;
      8'h04, 8'h05: m_pol[b +: 8]  = d;
      8'h06, 8'h07: m_cfg[b +: 8]  = d;
      8'h44, 8'h45: m_lat[b +: 8]  = d;
      8'h46, 8'h47: m_pen[b +: 8]  = d;
      8'h48, 8'h49: m_psel[b +: 8] = d;
      8'h4A, 8'h4B: m_msk[b +: 8]  = d;
      8'h4F:        m_od           = d[1:0];
      default: ;
    endcase
  endfunction

  task automatic check_state(input string tag);
    check(int_n === ~|exp_sts(), {tag, " int_n"}, {15'd0, int_n}, {15'd0, ~|exp_sts()});
    check(pin_oe === exp_oe(), {tag, " pin_oe"}, pin_oe, exp_oe());
    check(pin_out === m_out, {tag, " pin_out"}, pin_out, m_out);
    check(pull_en === m_pen && pull_up === m_psel, {tag, " pulls R11"}, pull_en ^ pull_up, m_pen ^ m_psel);
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [7:0] d, input string tag);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
    model_write(a, d); settle();
    repeat (3) @(negedge clk);
    check_state(tag);
  endtask

  task automatic do_rd(input logic [7:0] a, input string tag);
    logic [7:0] e;
    int b;
    e = exp_read(a);
    @(negedge clk); addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0;
    check(rdata === e, {tag, " rdata"}, {8'd0, rdata}, {8'd0, e});
    if (a == 8'h00 || a == 8'h01) begin
      b = a[0] ? 8 : 0;
      m_ref[b +: 8] = pins[b +: 8];
      m_hit[b +: 8] = '0;
      m_hv[b +: 8]  = '0;
    end
    settle();
    repeat (3) @(negedge clk);
    check_state(tag);
  endtask

  task automatic set_pins(input logic [15:0] v, input string tag);
    @(negedge clk); pin_in = v; pins = v;
    repeat (5) @(negedge clk);
    settle();
    check_state(tag);
  endtask

  function automatic logic [7:0] pick_addr(input int r);
    case (r % 20)
      0: return 8'h00;  1: return 8'h01;  2: return 8'h02;  3: return 8'h03;
      4: return 8'h04;  5: return 8'h05;  6: return 8'h06;  7: return 8'h07;
      8: return 8'h44;  9: return 8'h45; 10: return 8'h46; 11: return 8'h47;
     12: return 8'h48; 13: return 8'h49; 14: return 8'h4A; 15: return 8'h4B;
     16: return 8'h4C; 17: return 8'h4D; 18: return 8'h4F;
      default: return 8'h4E;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5eed_1234);
    pins = '0;
    model_reset();
    repeat (6) @(negedge clk);
    // R1: state while reset is still asserted
    check(int_n === 1'b1 && pin_oe === 16'h0 && pin_out === 16'hFFFF, "R1 outputs in reset",
          pin_oe, 16'h0);
    rst = 0;
    @(negedge clk);
    check_state("R1 after reset");
    do_rd(8'h06, "R1 cfg default");
    do_rd(8'h03, "R1 out default");
    do_rd(8'h48, "R1 pull dir default");
    do_rd(8'h4F, "R1 omode default");
    do_rd(8'h4A, "R7 mask default");
    do_rd(8'h4B, "R7 mask default p1");

    // R2: unmapped addresses
    do_wr(8'h4E, 8'hAA, "R2 unmapped write");
    do_rd(8'h4E, "R2 unmapped read");
    do_rd(8'h10, "R2 unmapped read");
    do_wr(8'h46, 8'h5A, "R2 pull enable write");
    do_rd(8'h46, "R2 pull enable read");

    // R3 / R7: pins change while masked, polarity applied on read
    set_pins(16'hA55A, "R7 masked change");
    check(int_n === 1'b1, "R7 int masked", {15'd0, int_n}, 16'd1);
    do_wr(8'h04, 8'h0F, "R3 polarity");
    do_rd(8'h00, "R3 input p0");
    do_wr(8'h00, 8'h33, "R3 input write ignored");
    do_wr(8'h4C, 8'h33, "R3 status write ignored");
    do_rd(8'h00, "R3 input after write");
    do_rd(8'h01, "R3 input p1");

    // R4 / R5: outputs and open-drain
    do_wr(8'h06, 8'h00, "R4 port0 outputs");
    do_wr(8'h02, 8'h3C, "R4 out value");
    check(pin_oe[7:0] === 8'hFF && pin_out[7:0] === 8'h3C, "R4 drive", {pin_oe[7:0], pin_out[7:0]}, 16'hFF3C);
    do_wr(8'h4F, 8'h01, "R5 open drain p0");
    check(pin_oe[7:0] === 8'hC3, "R5 released highs", {8'd0, pin_oe[7:0]}, 16'h00C3);

    // R6 / R8 / R10: interrupt on port 1
    do_wr(8'h4B, 8'h00, "R6 unmask p1");
    do_rd(8'h01, "R8 set reference");
    check(int_n === 1'b1, "R8 int clear", {15'd0, int_n}, 16'd1);
    set_pins(16'h5A5A, "R6 change p1");
    check(int_n === 1'b0, "R6 int low", {15'd0, int_n}, 16'd0);
    do_rd(8'h4D, "R10 status p1");
    do_rd(8'h01, "R8 read clears");
    check(int_n === 1'b1, "R8 int released", {15'd0, int_n}, 16'd1);

    // R12: output pins on port 0 unmasked do not interrupt
    do_wr(8'h4A, 8'h00, "R12 unmask p0");
    do_rd(8'h00, "R12 ref p0");
    set_pins(16'h5AA5, "R12 toggle outputs");
    do_rd(8'h4C, "R12 status p0");

    // R9: latched vs plain pin on port 1
    do_wr(8'h45, 8'h01, "R9 latch bit8");
    do_rd(8'h01, "R9 ref");
    set_pins(pins ^ 16'h0100, "R9 latched toggle");
    set_pins(pins ^ 16'h0100, "R9 latched return");
    check(int_n === 1'b0, "R9 held int", {15'd0, int_n}, 16'd0);
    do_rd(8'h01, "R9 held value");
    set_pins(pins ^ 16'h0200, "R9 plain toggle");
    set_pins(pins ^ 16'h0200, "R9 plain return");
    check(int_n === 1'b1, "R9 plain clears", {15'd0, int_n}, 16'd1);

    // Random phase
    for (int i = 0; i < 700; i++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 3)      set_pins(16'($urandom), "R6 random pins");
      else if (op < 6) do_wr(pick_addr($urandom), 8'($urandom), "R2 random write");
      else             do_rd(pick_addr($urandom), "R10 random read");
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule